// File: doc/BRIEF.md
# Character Display Host Bus Port

This block is the processor-facing front end of a character display controller. A host drives a register-select line, a read/write line, an enable strobe and an 8-line data bus. The bus is split here into an input side, an output side and an output enable. The block latches each write into either the instruction path or the data path. Writes to the instruction path are refused while an internal operation is still busy. On reads, the block returns a status word or a buffered display memory word.

The data bus runs either 8 lines wide or 4 lines wide. The choice follows a bit in the function-set instruction and can change at run time. In the narrow mode a byte moves as two strobes, upper half first. The block keeps track of which half comes next. Data reads are served from a prefetch buffer that is reloaded at the end of every data access. A read therefore returns the word captured at the previous data access, and an address-set instruction alone does not refresh the buffer. The display core behind the block supplies the address counter and the memory word at that address. It consumes the instruction, data-write and data-read-done pulses.

Top module: `disp_host_port`

## Requirements
- R1: A write with regSel low gives a one-cycle instrValid pulse carrying the byte on instrByte. A write with regSel high gives a one-cycle dataWrValid pulse carrying the byte on dataWrByte.
- R2: A read with regSel low returns a status byte: the busy flag on line 7 and the 7-bit addrCounter on lines 6..0.
- R3: A read with regSel high returns the prefetch buffer and gives a one-cycle dataRdDone pulse. The buffer is reloaded with ramData at the completion of every data read and every data write.
- R4: The prefetch buffer is zero after reset, and an instruction write (including an address set, top bit 1) leaves it unchanged, so the following data read returns the stale word.
- R5: The busy flag goes high after each accepted instruction or each data write and stays high for BUSY_CYCLES clock cycles, then clears.
- R6: An instruction write that completes while busy is high is discarded (no instrValid pulse). Data writes are accepted regardless of busy.
- R7: After reset the bus is 8 lines wide. An accepted instruction whose bits 7..5 are 001 (function set) selects the 8-line bus when bit 4 is 1 and the 4-line bus when bit 4 is 0.
- R8: On the 4-line bus, only dataIn[7:4] is used. Each byte takes two strobes: the upper nibble first, then the lower nibble. The byte is delivered after the second strobe, and dataIn[3:0] is ignored.
- R9: On the 4-line bus, a read presents the upper nibble of the read word on dataOut[7:4] during the first strobe and the lower nibble during the second. dataOut[3:0] is zero.
- R10: An accepted function-set instruction resets the nibble phase so that the next transfer is an upper half.
- R11: dataOe is high only while enable is high and readNotWrite is high. dataOut is zero whenever dataOe is low.
- R12: A transfer completes on the falling edge of enable. The result pulse appears in the first clock cycle after the clock edge that sees enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | 0: instruction/status, 1: data |
| readNotWrite | input | 1 | 1: read, 0: write |
| enable | input | 1 | Transfer strobe, completes on falling edge |
| dataIn | input | 8 | Bus lines driven by the host |
| dataOut | output | 8 | Bus lines driven by the block |
| dataOe | output | 1 | Output enable for dataOut |
| addrCounter | input | 7 | Current address counter from the core |
| ramData | input | 8 | Display memory word at the current address |
| instrValid | output | 1 | Accepted instruction pulse |
| instrByte | output | 8 | Accepted instruction byte |
| dataWrValid | output | 1 | Data write pulse |
| dataWrByte | output | 8 | Data write byte |
| dataRdDone | output | 1 | Data read completed pulse |

## Verification
The bench tests writes in both bus widths. In the narrow tests the unused lower lines carry junk, so any leak of dataIn[3:0] into an assembled byte shows up. A chain of data reads with a different ramData before each one, with an address-set instruction in between, separates a correct one-access lag from a buffer that is transparent or refreshed by instructions. Back-to-back instructions with a data write between them separate refusal of instructions while busy from refusal of all writes. Status reads taken just after a write and again after the busy window confirm that the flag both sets and clears.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int ADDR_W = BYTE_W - 1;

  typedef struct packed {
    logic hiLoad;
    logic instrFire;
    logic dataFire;
    logic rdFire;
    logic bufLoad;
  } hostStrb_t;
endpackage

// File: rtl/disp_host_ctl.sv
module disp_host_ctl
  import disp_host_pkg::*;
#(
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              capRs,
  input  logic              capRw,
  input  logic [BYTE_W-1:0] fullByte,
  output hostStrb_t         strb,
  output logic              busy,
  output logic              wideMode,
  output logic              phase
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

  logic             enPrev;
  logic [CNT_W-1:0] busyCnt;
  logic             fall, lastHalf, xferDone, accInstr, isFuncSet;

  always_ff @(posedge clk) begin
    if (!rstN) enPrev <= 1'b0;
    else       enPrev <= enable;
  end

  assign fall      = enPrev & ~enable;
  assign lastHalf  = wideMode | phase;
  assign xferDone  = fall & lastHalf;
  assign isFuncSet = (fullByte[BYTE_W-1 -: 3] == 3'b001);
  assign accInstr  = xferDone & ~capRw & ~capRs & ~busy;

  always_comb begin
    strb.hiLoad    = fall & ~wideMode & ~phase & ~capRw;
    strb.instrFire = accInstr;
    strb.dataFire  = xferDone & ~capRw & capRs;
    strb.rdFire    = xferDone & capRw & capRs;
    strb.bufLoad   = strb.dataFire | strb.rdFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wideMode <= 1'b1;
      phase    <= 1'b0;
    end else if (accInstr && isFuncSet) begin
      wideMode <= fullByte[NIB_W];
      phase    <= 1'b0;
    end else if (fall && !wideMode) begin
      phase <= ~phase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              busyCnt <= '0;
    else if (accInstr || strb.dataFire)     busyCnt <= BUSY_LOAD;
    else if (busyCnt != '0)                 busyCnt <= busyCnt - 1'b1;
  end

  assign busy = (busyCnt != '0);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> busyCnt == BUSY_LOAD);
  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(busyCnt) == CNT_W'(1));
  // R8
  narrow_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.instrFire || strb.dataFire || strb.rdFire) && !wideMode |-> phase);
  // R7
  mode_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wideMode) |-> $past(strb.instrFire));
endmodule

// File: rtl/disp_host_dp.sv
module disp_host_dp
  import disp_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              regSel,
  input  logic              readNotWrite,
  input  logic [BYTE_W-1:0] dataIn,
  input  hostStrb_t         strb,
  input  logic              busy,
  input  logic              wideMode,
  input  logic              phase,
  input  logic [ADDR_W-1:0] addrCounter,
  input  logic [BYTE_W-1:0] ramData,
  output logic              capRs,
  output logic              capRw,
  output logic [BYTE_W-1:0] fullByte,
  output logic [BYTE_W-1:0] dataOut,
  output logic              dataOe,
  output logic              instrValid,
  output logic [BYTE_W-1:0] instrByte,
  output logic              dataWrValid,
  output logic [BYTE_W-1:0] dataWrByte,
  output logic              dataRdDone
);
  logic [BYTE_W-1:0] capData, readBuf, readWord;
  logic [NIB_W-1:0]  hiNib, outNib;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capRs   <= 1'b0;
      capRw   <= 1'b0;
      capData <= '0;
    end else if (enable) begin
      capRs   <= regSel;
      capRw   <= readNotWrite;
      capData <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            hiNib <= '0;
    else if (strb.hiLoad) hiNib <= capData[BYTE_W-1 -: NIB_W];
  end

  assign fullByte = wideMode ? capData : {hiNib, capData[BYTE_W-1 -: NIB_W]};

  always_ff @(posedge clk) begin
    if (!rstN)             readBuf <= '0;
    else if (strb.bufLoad) readBuf <= ramData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrValid  <= 1'b0;
      dataWrValid <= 1'b0;
      dataRdDone  <= 1'b0;
      instrByte   <= '0;
      dataWrByte  <= '0;
    end else begin
      instrValid  <= strb.instrFire;
      dataWrValid <= strb.dataFire;
      dataRdDone  <= strb.rdFire;
      if (strb.instrFire) instrByte  <= fullByte;
      if (strb.dataFire)  dataWrByte <= fullByte;
    end
  end

  assign readWord = regSel ? readBuf : {busy, addrCounter};
  assign outNib   = phase ? readWord[NIB_W-1:0] : readWord[BYTE_W-1 -: NIB_W];
  assign dataOe   = enable & readNotWrite;

  always_comb begin
    if (!dataOe)       dataOut = '0;
    else if (wideMode) dataOut = readWord;
    else               dataOut = {outNib, {NIB_W{1'b0}}};
  end

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);
  // R12
  instr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> !instrValid);
  // R6
  instr_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |-> $past(!busy));
  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRdDone |=> !dataRdDone);
endmodule

// File: rtl/disp_host_port.sv
module disp_host_port
  import disp_host_pkg::*;
#(
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              readNotWrite,
  input  logic              enable,
  input  logic [BYTE_W-1:0] dataIn,
  output logic [BYTE_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [ADDR_W-1:0] addrCounter,
  input  logic [BYTE_W-1:0] ramData,
  output logic              instrValid,
  output logic [BYTE_W-1:0] instrByte,
  output logic              dataWrValid,
  output logic [BYTE_W-1:0] dataWrByte,
  output logic              dataRdDone
);
  hostStrb_t         strb;
  logic              busy, wideMode, phase, capRs, capRw;
  logic [BYTE_W-1:0] fullByte;

  disp_host_ctl #(.BUSY_CYCLES(BUSY_CYCLES)) ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .capRs(capRs), .capRw(capRw),
    .fullByte(fullByte), .strb(strb), .busy(busy), .wideMode(wideMode),
    .phase(phase)
  );

  disp_host_dp dp (
    .clk(clk), .rstN(rstN), .enable(enable), .regSel(regSel),
    .readNotWrite(readNotWrite), .dataIn(dataIn), .strb(strb), .busy(busy),
    .wideMode(wideMode), .phase(phase), .addrCounter(addrCounter),
    .ramData(ramData), .capRs(capRs), .capRw(capRw), .fullByte(fullByte),
    .dataOut(dataOut), .dataOe(dataOe), .instrValid(instrValid),
    .instrByte(instrByte), .dataWrValid(dataWrValid), .dataWrByte(dataWrByte),
    .dataRdDone(dataRdDone)
  );
endmodule

// File: tb/disp_host_port_test.sv
module disp_host_port_test;
  localparam int BUSY = 6;
  logic clk = 1'b0, rstN = 1'b0;
  logic regSel = 1'b0, readNotWrite = 1'b0, enable = 1'b0;
  logic [7:0] dataIn = '0, ramData = '0;
  logic [6:0] addrCounter = 7'h2A;
  logic [7:0] dataOut, instrByte, dataWrByte;
  logic dataOe, instrValid, dataWrValid, dataRdDone;

  int checks = 0, errors = 0;
  bit benchWide = 1'b1;
  bit finished = 1'b0;
  logic [9:0] expQ[$];   // {kind, byte}: kind 1 instr, 2 data write, 3 data read

  always #10 clk = ~clk;

  disp_host_port #(.BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .readNotWrite(readNotWrite),
    .enable(enable), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .addrCounter(addrCounter), .ramData(ramData), .instrValid(instrValid),
    .instrByte(instrByte), .dataWrValid(dataWrValid), .dataWrByte(dataWrByte),
    .dataRdDone(dataRdDone)
  );

  task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when the design produces a result pulse.
  always @(negedge clk) begin
    if (rstN && (instrValid || dataWrValid || dataRdDone)) begin
      logic [9:0] got;
      got = instrValid ? {2'd1, instrByte} : dataWrValid ? {2'd2, dataWrByte} : {2'd3, 8'h00};
      if (expQ.size() == 0) check(got, 10'h000, "R1/R6 unexpected result pulse");
      else check(got, expQ.pop_front(), "R1/R3/R8 scoreboard item");
    end
  end

  task automatic strobe(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] seen);
    @(negedge clk);
    regSel = rs; readNotWrite = rw; dataIn = d; enable = 1'b1;
    @(negedge clk);
    seen = dataOut;
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic rs, input logic [7:0] b, input bit accept);
    logic [7:0] s;
    if (accept) expQ.push_back({rs ? 2'd2 : 2'd1, b});
    if (benchWide) strobe(rs, 1'b0, b, s);
    else begin
      strobe(rs, 1'b0, {b[7:4], 4'hA}, s);
      strobe(rs, 1'b0, {b[3:0], 4'h5}, s);
    end
  endtask

  task automatic hostRead(input logic rs, output logic [7:0] b);
    logic [7:0] s1, s2;
    if (rs) expQ.push_back({2'd3, 8'h00});
    if (benchWide) strobe(rs, 1'b1, 8'hFF, b);
    else begin
      strobe(rs, 1'b1, 8'hFF, s1);
      strobe(rs, 1'b1, 8'hFF, s2);
      check({2'b0, s1[3:0], s2[3:0]}, 10'h000, "R9 low lines zero in narrow read");
      b = {s1[7:4], s2[7:4]};
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    idle(3);
    // R11 R12 reset state
    check({dataOe, instrValid, dataWrValid, dataRdDone, 6'b0}, 10'h000, "R12 reset pulses low");
    check({2'b0, dataOut}, 10'h000, "R11 reset dataOut zero");
    rstN = 1'b1;
    idle(2);

    // R2 R7: status read on the wide bus right after reset
    hostRead(1'b0, r); check({2'b0, r}, 10'h02A, "R2 status idle");
    // R4: first data read returns the cleared buffer
    ramData = 8'hA5;
    hostRead(1'b1, r); check({2'b0, r}, 10'h000, "R4 first read after reset");
    // R3: lag of one access
    ramData = 8'h3C;
    hostRead(1'b1, r); check({2'b0, r}, 10'h0A5, "R3 previous access word");

    // R1 instruction then data
    hostWrite(1'b0, 8'h01, 1'b1); idle(BUSY + 4);
    hostWrite(1'b1, 8'h48, 1'b1);
    // R5 busy visible right after a data write, then clears
    hostRead(1'b0, r); check({2'b0, r}, 10'h0AA, "R5 busy set after write");
    idle(BUSY + 4);
    hostRead(1'b0, r); check({2'b0, r}, 10'h02A, "R5 busy cleared");

    // R4 address set does not refresh buffer
    ramData = 8'h77;
    hostWrite(1'b0, 8'h80, 1'b1); idle(BUSY + 4);
    hostRead(1'b1, r); check({2'b0, r}, 10'h03C, "R4 stale after address set");
    hostRead(1'b1, r); check({2'b0, r}, 10'h077, "R3 buffer after reload");

    // R6 instruction refused while busy, data write accepted
    hostWrite(1'b0, 8'h0C, 1'b1);
    hostWrite(1'b0, 8'h0E, 1'b0);
    hostWrite(1'b1, 8'h55, 1'b1);
    idle(BUSY + 4);
    hostWrite(1'b0, 8'h06, 1'b1); idle(BUSY + 4);
    check({9'b0, dataOe}, 10'h000, "R11 no drive while idle");

    // R7 R10 switch to narrow bus
    hostWrite(1'b0, 8'h28, 1'b1); benchWide = 1'b0; idle(BUSY + 4);
    // R8 narrow writes with junk on the low lines
    hostWrite(1'b0, 8'h0F, 1'b1); idle(BUSY + 4);
    hostWrite(1'b1, 8'h9B, 1'b1); idle(BUSY + 4);
    // R9 narrow reads
    hostRead(1'b0, r); check({2'b0, r}, 10'h02A, "R9 narrow status");
    ramData = 8'hC3;
    hostRead(1'b1, r); check({2'b0, r}, 10'h077, "R9 narrow data read");
    hostRead(1'b1, r); check({2'b0, r}, 10'h0C3, "R9 narrow second read");

    // R7 R10 back to the wide bus
    hostWrite(1'b0, 8'h30, 1'b1); benchWide = 1'b1; idle(BUSY + 4);
    hostRead(1'b0, r); check({2'b0, r}, 10'h02A, "R7 wide status again");
    hostWrite(1'b1, 8'h5A, 1'b1); idle(BUSY + 4);

    // R11 output enable follows the strobe for reads only
    @(negedge clk); regSel = 1'b0; readNotWrite = 1'b1; enable = 1'b1;
    @(negedge clk); check({9'b0, dataOe}, 10'h001, "R11 drive during read");
    enable = 1'b0;
    @(negedge clk); check({9'b0, dataOe}, 10'h000, "R11 release after read");
    readNotWrite = 1'b0;
    idle(3);

    // R1 R12 every expected pulse arrived
    check(10'(expQ.size()), 10'h000, "R12 scoreboard drained");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule